// File: doc/BRIEF.md
# NRZI Header-Aligned Word Receiver

This block sits at the receiving end of a single serial data line. The line carries 30-bit words. Each word is a 5-bit header followed by a 25-bit payload, and the whole stream is NRZI coded. The block first turns line levels back into data bits. A level change between successive line bits is a 1 and a held level is a 0, with the reference level taken as 0 after reset. It then hunts for the header pattern `00011` in the decoded bits. It locks once two headers are seen exactly one word apart. While locked, it rechecks the header at every word boundary, so a corrupted word is dropped and alignment is recovered within a few words.

Each payload is released only after the header that follows it has been confirmed. This means a word whose trailing boundary is broken is never delivered. Independently of framing, the block watches the line for runs of equal levels longer than the coding allows (at most four) and flags each offending bit.

Top module: `nrzi_word_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `payload`, `payload_vld`, `locked`, `hdr_err` and `run_err` are all 0 after that edge.
- R2: NRZI decoding: a line bit that differs from the previous line bit decodes as 1, an equal one as 0; the first line bit sampled after reset is compared against level 0, whatever the line held during reset.
- R3: From hunting, the block locks when a decoded header `00011` (first-received bit leftmost) is followed by a second one ending exactly 30 decoded bits later; `locked` rises in the same cycle as the first `payload_vld`.
- R4: Each `payload` holds the 25 decoded bits that follow a header, first-received bit in bit 24. It is presented with a `payload_vld` pulse one cycle wide, once the header after it has been confirmed.
- R5: While locked, if the 5 bits ending 30 bits after the previous header are not `00011`, `hdr_err` pulses for one cycle, `locked` falls in that cycle, and the pending payload is never presented.
- R6: After a loss of lock, the block locks again on the next two headers 30 bits apart and resumes delivering payloads.
- R7: `run_err` pulses for every decoded 0 that is the fourth or later in a row, since such a bit makes five or more equal line levels. The zero count is reset by a decoded 1 and starts at 0 after reset. Run errors do not affect framing or payload delivery.
- R8: `hdr_err`, `payload_vld` and `run_err` each change two clock edges after the line sample of the bit that causes them. A header corrupted by a long run therefore raises `hdr_err` and `run_err` in the same cycle.
- R9: When the second header of a lock attempt is missing, the block returns to hunting with no `hdr_err`, no `payload_vld` and `locked` kept low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one line bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | NRZI-coded serial line level |
| payload | output | 25 | Last delivered payload, first-received bit in bit 24 |
| payload_vld | output | 1 | One-cycle strobe marking a new payload |
| locked | output | 1 | Word alignment is established |
| hdr_err | output | 1 | One-cycle pulse: header missing at an expected boundary while locked |
| run_err | output | 1 | One-cycle pulse: line held one level for more than four bits |

## Verification
Two functions can fall in the same cycle: the header check at a word boundary and the run-length monitor. The bench provokes this while locked by sending a word whose header decodes as `10000`. That header holds the line for five levels, ending exactly on the boundary bit. The bench judges the result by counting cycles in which both flags are high together, and requires exactly one such cycle. It also requires that no payload was released for the word before the bad header and that `locked` is low afterwards.

// File: rtl/nrzi_rx_pkg.sv
// Shared types for the NRZI header-aligned word receiver.
package nrzi_rx_pkg;

    // Framer alignment state.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,  // sliding search for a header
        ST_CONFIRM = 2'd1,  // one header seen, waiting for the next
        ST_LOCK    = 2'd2   // aligned, checking every boundary
    } frame_state_t;

endpackage

// File: rtl/nrzi_rx_decoder.sv
// NRZI decoder.
// Converts line levels to data bits: change = 1, no change = 0.
// Assumes one line bit per clock. The reference level is forced to 0 by
// reset, so the first bit after reset is compared against 0.
// bit_vld marks that bit_out holds a real decoded bit (not reset filler).
module nrzi_rx_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_out,
    output logic bit_vld
);

    logic ref_lvl;

    // Register previous level and the decoded bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lvl <= 1'b0;
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            ref_lvl <= line_in;
            bit_out <= line_in ^ ref_lvl;
            bit_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/nrzi_rx_runmon.sv
// Run-length monitor.
// Counts consecutive decoded zeros (held line levels). A run of MAX_LEVELS
// decoded zeros means MAX_LEVELS+1 equal levels, which the coding forbids;
// every such zero, and each further one, raises a one-cycle run_err.
// Works on the decoded stream so its latency matches the framer.
module nrzi_rx_runmon #(
    parameter int MAX_LEVELS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic run_err
);

    localparam int ZW = $clog2(MAX_LEVELS + 1);
    localparam logic [ZW-1:0] ZMAX = ZW'(MAX_LEVELS);
    localparam logic [ZW-1:0] ZLIM = ZW'(MAX_LEVELS - 1);

    logic [ZW-1:0] zrun;

    // Track the zero run and flag bits that extend it past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun    <= '0;
            run_err <= 1'b0;
        end else begin
            run_err <= 1'b0;
            if (bit_vld) begin
                if (bit_in) begin
                    zrun <= '0;
                end else begin
                    if (zrun != ZMAX) zrun <= zrun + 1'b1;
                    if (zrun >= ZLIM) run_err <= 1'b1;
                end
            end
        end
    end

    AST_RUN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_err |-> $past(bit_vld && !bit_in));                     // R7
    AST_RUN_CLEARS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in) |=> !run_err);                           // R7

endmodule

// File: rtl/nrzi_rx_framer.sv
// Word framer.
// Slides a HDR_BITS window over decoded bits to find HDR_PAT, confirms it
// one word later, then checks every boundary. Payload bits between two
// headers are collected MSB first and released only when the closing
// header matches. A miss while locked raises hdr_err and returns to hunt.
// Assumes HDR_PAT has a 0 in its first bit so the all-ones reset window
// cannot match before HDR_BITS real bits have arrived.
module nrzi_rx_framer
    import nrzi_rx_pkg::*;
#(
    parameter int WORD_BITS = 30,
    parameter int HDR_BITS  = 5,
    parameter logic [HDR_BITS-1:0] HDR_PAT = 5'b00011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_in,
    input  logic                          bit_vld,
    output logic [WORD_BITS-HDR_BITS-1:0] payload,
    output logic                          payload_vld,
    output logic                          locked,
    output logic                          hdr_err
);

    localparam int PAY_BITS = WORD_BITS - HDR_BITS;
    localparam int CNT_W    = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(PAY_BITS);

    frame_state_t          state;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      cnt_n;
    logic [HDR_BITS-1:0]   win;
    logic [HDR_BITS-1:0]   win_n;
    logic                  match;
    logic [PAY_BITS-1:0]   pay_sh;

    // Next window, header compare and bit position.
    always_comb begin
        win_n = {win[HDR_BITS-2:0], bit_in};
        match = (win_n == HDR_PAT);
        cnt_n = cnt + 1'b1;
    end

    // Alignment state machine, payload collection and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HUNT;
            cnt         <= '0;
            win         <= '1;
            pay_sh      <= '0;
            payload     <= '0;
            payload_vld <= 1'b0;
            hdr_err     <= 1'b0;
        end else begin
            payload_vld <= 1'b0;
            hdr_err     <= 1'b0;
            if (bit_vld) begin
                win <= win_n;
                if (state == ST_HUNT) begin
                    if (match) begin
                        state <= ST_CONFIRM;
                        cnt   <= '0;
                    end
                end else begin
                    cnt <= cnt_n;
                    if (cnt_n <= CNT_PAY) pay_sh <= {pay_sh[PAY_BITS-2:0], bit_in};
                    if (cnt_n == CNT_WORD) begin
                        cnt <= '0;
                        if (match) begin
                            state       <= ST_LOCK;
                            payload     <= pay_sh;
                            payload_vld <= 1'b1;
                        end else begin
                            state   <= ST_HUNT;
                            hdr_err <= (state == ST_LOCK);
                        end
                    end
                end
            end
        end
    end

    // Lock flag straight from the state.
    assign locked = (state == ST_LOCK);

    AST_LOCK_RISES_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> payload_vld);                              // R3
    AST_VLD_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        payload_vld |-> locked);                                     // R4
    AST_VLD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        payload_vld |=> !payload_vld);                               // R4
    AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> (!locked && !payload_vld));                      // R5
    AST_ERR_NEEDS_PRIOR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> $past(locked));                                  // R9

endmodule

// File: rtl/nrzi_word_rx.sv
// NRZI header-aligned word receiver, top level.
// One serial line in; decodes NRZI, aligns on a per-word header, releases
// the payload with a strobe and flags header and run-length violations.
// Assumes one line bit per rising clock edge and a synchronous reset.
module nrzi_word_rx #(
    parameter int WORD_BITS  = 30,
    parameter int HDR_BITS   = 5,
    parameter logic [HDR_BITS-1:0] HDR_PAT = 5'b00011,
    parameter int MAX_LEVELS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_in,
    output logic [WORD_BITS-HDR_BITS-1:0] payload,
    output logic                          payload_vld,
    output logic                          locked,
    output logic                          hdr_err,
    output logic                          run_err
);

    logic dec_bit;
    logic dec_vld;

    nrzi_rx_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .bit_out (dec_bit),
        .bit_vld (dec_vld)
    );

    nrzi_rx_runmon #(
        .MAX_LEVELS (MAX_LEVELS)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (dec_bit),
        .bit_vld (dec_vld),
        .run_err (run_err)
    );

    nrzi_rx_framer #(
        .WORD_BITS (WORD_BITS),
        .HDR_BITS  (HDR_BITS),
        .HDR_PAT   (HDR_PAT)
    ) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (dec_bit),
        .bit_vld     (dec_vld),
        .payload     (payload),
        .payload_vld (payload_vld),
        .locked      (locked),
        .hdr_err     (hdr_err)
    );

endmodule

// File: tb/nrzi_word_rx_test.sv
`timescale 1ns/1ps
module nrzi_word_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic [24:0] payload;
    logic        payload_vld, locked, hdr_err, run_err;

    nrzi_word_rx uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .payload(payload), .payload_vld(payload_vld), .locked(locked),
        .hdr_err(hdr_err), .run_err(run_err)
    );

    always #2 clk = ~clk;  // 250 MHz

    int n_chk = 0, n_err = 0;
    int vld_seen = 0, herr_seen = 0, rerr_seen = 0, both_seen = 0;
    logic [24:0] last_pay = '0;

    // Bench model of the line and of expected run errors.
    logic lvl = 1'b0;
    int zrun = 0, exp_run = 0, exp_lag1 = 0, exp_lag2 = 0;

    localparam logic [4:0]  HDR  = 5'b00011;
    localparam logic [24:0] ONES = 25'h1FFFFFF;

    // Output event counters, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (payload_vld) begin vld_seen++; last_pay = payload; end
            if (hdr_err) herr_seen++;
            if (run_err) rerr_seen++;
            if (hdr_err && run_err) both_seen++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one decoded bit as an NRZI level; returns just after the sampling edge.
    task automatic send_dbit(input logic b);
        if (b) lvl = ~lvl;
        line_in = lvl;
        exp_lag2 = exp_lag1;
        exp_lag1 = exp_run;
        if (b) zrun = 0;
        else begin zrun++; if (zrun >= 4) exp_run++; end
        @(posedge clk); #1;
    endtask

    task automatic send_word(input logic [4:0] h, input logic [24:0] p);
        for (int i = 4; i >= 0; i--) send_dbit(h[i]);
        for (int i = 24; i >= 0; i--) send_dbit(p[i]);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [24:0] prev, p;
        int v0, h0, r0;
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        chk("R1 payload", int'(payload), 0);
        chk("R1 flags", int'({payload_vld, locked, hdr_err, run_err}), 0);

        // R2/R3: header right after reset (first bit decoded against level 0)
        rst_n = 1'b1;
        send_word(HDR, 25'h1555555);
        chk("R3 not locked after one header", int'(locked), 0);
        send_word(HDR, 25'h0ABCDEF);
        chk("R3 locked after two headers", int'(locked), 1);
        chk("R2 R4 first payload", int'(last_pay), 32'h1555555);
        chk("R4 one strobe", vld_seen, 1);

        // R4: sweep of computed payloads while locked
        prev = 25'h0ABCDEF;
        for (int i = 0; i < 24; i++) begin
            p = 25'((i * 32'h00A35C71) + 32'h00123457);
            send_word(HDR, p);
            chk("R4 payload value", int'(last_pay), int'(prev));
            chk("R4 strobe count", vld_seen, i + 2);
            prev = p;
        end
        chk("R7 run errors match model", rerr_seen, exp_lag2);

        // R7: explicit six-zero run inside a payload, lock unaffected
        send_word(HDR, ONES);
        r0 = rerr_seen;
        send_word(HDR, 25'h103FFFF);
        chk("R7 three run errors", rerr_seen - r0, 3);
        send_word(HDR, ONES);
        chk("R7 payload delivered through run", int'(last_pay), 32'h103FFFF);
        chk("R7 still locked", int'(locked), 1);
        chk("R5 no header error yet", herr_seen, 0);

        // R5/R8: corrupted header 10000 while locked
        v0 = vld_seen;
        send_word(5'b10000, ONES);
        chk("R5 header error pulse", herr_seen, 1);
        chk("R5 lock dropped", int'(locked), 0);
        chk("R5 payload discarded", vld_seen, v0);
        chk("R8 both flags same cycle", both_seen, 1);

        // R9: first header then a missing one, no lock, no error
        h0 = herr_seen;
        send_word(HDR, ONES);
        send_word(5'b11111, ONES);
        chk("R9 no header error", herr_seen, h0);
        chk("R9 not locked", int'(locked), 0);
        chk("R9 no strobe", vld_seen, v0);

        // R6: recovery
        send_word(HDR, ONES);
        send_word(HDR, 25'h1555555);
        chk("R6 relocked", int'(locked), 1);
        chk("R6 payload after relock", int'(last_pay), 32'h1FFFFFF);
        send_word(HDR, ONES);
        chk("R6 next payload", int'(last_pay), 32'h1555555);
        chk("R7 run errors match model overall", rerr_seen, exp_lag2);

        // R2: reset with line high; the reference must still be level 0
        rst_n = 1'b0; line_in = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk("R1 locked cleared", int'(locked), 0);
        lvl = 1'b0; zrun = 0;
        rst_n = 1'b1;
        v0 = vld_seen;
        send_word(HDR, 25'h0F0F0F3);
        send_word(HDR, 25'h1234567);
        chk("R2 lock after reset with line high", int'(locked), 1);
        chk("R2 payload after reset", int'(last_pay), 32'h0F0F0F3);
        chk("R2 strobe count", vld_seen - v0, 1);

        finish_run();
    end

endmodule